// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block sits next to one processor and decides which interrupt that processor sees. It keeps a 32-bit presentation word whose upper byte is the processor's current priority threshold and whose lower 24 bits name the pending source. Beside it sit an 8-bit pending priority and an 8-bit inter-processor-interrupt (IPI) request priority. A source controller offers interrupts as a source number with a priority. The block either takes the offer or bounces it back. If it takes the offer, any source that was waiting and that the source controller owns is bounced back instead. The block drives one interrupt line to the processor.

Software works on the block through a small command port. It can accept the pending interrupt, poll it, signal end-of-interrupt, move the priority threshold and set the IPI priority. Towards the source controller the block issues three single-cycle strobes: reject (with a source number), end-of-interrupt (with a source number) and a resend request. A lower priority number is more favoured, and 0xFF means masked or nothing pending.

Top module: `irq_presenter`

## Requirements
- R1: After reset the presentation word is zero, the pending priority and the IPI priority are 0xFF, the interrupt output is low, and no strobe or response is active.
- R2: The response word carries the priority threshold in bits 31:24 and the pending source in bits 23:0. A source of zero means nothing is pending, and irq_out is high exactly when the pending source is non-zero. Responses and strobes appear in the cycle after the command or request that causes them and last one cycle.
- R3: A request with non-zero source and priority p is taken only if p is below the threshold and either nothing is pending or p is below the pending priority. A request with source zero has no effect.
- R4: A non-zero request that is not taken is rejected with its own source number.
- R5: A taken request latches the new source and priority, marks the source controller as owner and raises irq_out. If a source-controller-owned source was pending, that source is rejected.
- R6: Accept (op 1) returns the presentation word and lowers irq_out. It then loads the threshold with the pending priority, clears the pending source and ownership, and sets the pending priority to 0xFF.
- R7: Poll (op 0) returns the presentation word and changes no state and no output.
- R8: Set-threshold (op 3, value in cmd_data[7:0]) with a value below the old threshold stores it. If a source is pending whose pending priority is not below the new value, that source is cleared, the pending priority becomes 0xFF, irq_out falls, and the source is rejected if the source controller owns it.
- R9: Set-threshold with a value equal to or above the old threshold stores it, issues a resend request and runs the IPI check.
- R10: Set-IPI-priority (op 4, value in cmd_data[7:0]) stores the value and runs the IPI check.
- R11: The IPI check acts only when the IPI priority is below the threshold, and then only if nothing is pending or the pending priority is above the IPI priority. When it acts, any owned pending source is rejected, the pending source becomes 2, the pending priority becomes the IPI priority, ownership is cleared and irq_out rises. A pending IPI is never rejected when it is displaced.
- R12: End-of-interrupt (op 2) loads the threshold from cmd_data[31:24], forwards cmd_data[23:0] on the end-of-interrupt strobe, issues a resend request and runs the IPI check.
- R13: cmd_ready is always high. A command wins over a request in the same cycle, and req_ready is low while cmd_valid is high. Op codes 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Presentation request from source controller |
| req_ready | output | 1 | Request is consumed this cycle |
| req_src | input | 24 | Requested source number |
| req_prio | input | 8 | Requested priority |
| cmd_valid | input | 1 | Software command valid |
| cmd_ready | output | 1 | Command accepted (always high) |
| cmd_op | input | 3 | Command code |
| cmd_data | input | 32 | Command operand |
| rsp_valid | output | 1 | Response word valid |
| rsp_data | output | 32 | Presentation word returned by accept or poll |
| irq_out | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Reject strobe to source controller |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt strobe to source controller |
| eoi_src | output | 24 | Source number being retired |
| resend_req | output | 1 | Ask the source controller to re-offer its sources |

## Verification
Every result is registered once. A command or request that meets a rising edge has its response, strobes and new irq_out level visible just after that edge, and its effect on the presentation word shows in the response to a poll issued on the following cycle. The bench drives each stimulus on a falling edge, holds it across exactly one rising edge, and compares every output on the next falling edge against a requirement-level model. It then polls and compares the whole word, so each check falls in the cycle where the result is due.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

    parameter int unsigned PRIO_W = 8;
    parameter int unsigned SRC_W  = 24;
    localparam int unsigned WORD_W = PRIO_W + SRC_W;

    typedef enum logic [2:0] {
        OP_POLL     = 3'd0,
        OP_ACCEPT   = 3'd1,
        OP_EOI      = 3'd2,
        OP_SET_THR  = 3'd3,
        OP_SET_IPI  = 3'd4
    } irqp_op_e;

    typedef struct packed {
        logic [PRIO_W-1:0] thr;
        logic [SRC_W-1:0]  src;
        logic [PRIO_W-1:0] pend_prio;
        logic [PRIO_W-1:0] ipi_prio;
        logic              owned;
        logic              irq;
        logic              rsp_v;
        logic [WORD_W-1:0] rsp_d;
        logic              rej_v;
        logic [SRC_W-1:0]  rej_s;
        logic              eoi_v;
        logic [SRC_W-1:0]  eoi_s;
        logic              resend;
    } irqp_state_t;

endpackage

// File: rtl/irqp_admit.sv
module irqp_admit #(
    parameter int unsigned PW = 8
) (
    input  logic [PW-1:0] in_prio,
    input  logic [PW-1:0] thr,
    input  logic          busy,
    input  logic [PW-1:0] pend_prio,
    output logic          take
);
    logic below_thr;
    logic beats_pending;

    always_comb begin
        below_thr     = in_prio < thr;
        beats_pending = !busy || (in_prio < pend_prio);
        take          = below_thr && beats_pending;
    end

endmodule

// File: rtl/irqp_ipi.sv
module irqp_ipi #(
    parameter int unsigned PW = 8
) (
    input  logic          en,
    input  logic [PW-1:0] ipi_prio,
    input  logic [PW-1:0] thr,
    input  logic          busy,
    input  logic          owned,
    input  logic [PW-1:0] pend_prio,
    output logic          fire,
    output logic          bounce_old
);
    logic wins;

    always_comb begin
        wins       = !busy || (pend_prio > ipi_prio);
        fire       = en && (ipi_prio < thr) && wins;
        bounce_old = fire && busy && owned;
    end

endmodule

// File: rtl/irq_presenter.sv
module irq_presenter #(
    parameter int unsigned IPI_SRC = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [irqp_pkg::SRC_W-1:0]  req_src,
    input  logic [irqp_pkg::PRIO_W-1:0] req_prio,
    input  logic                        cmd_valid,
    output logic                        cmd_ready,
    input  logic [2:0]                  cmd_op,
    input  logic [irqp_pkg::WORD_W-1:0] cmd_data,
    output logic                        rsp_valid,
    output logic [irqp_pkg::WORD_W-1:0] rsp_data,
    output logic                        irq_out,
    output logic                        rej_valid,
    output logic [irqp_pkg::SRC_W-1:0]  rej_src,
    output logic                        eoi_valid,
    output logic [irqp_pkg::SRC_W-1:0]  eoi_src,
    output logic                        resend_req
);
    import irqp_pkg::*;

    localparam logic [PRIO_W-1:0] MASKED  = '1;
    localparam logic [SRC_W-1:0]  IPI_NUM = SRC_W'(IPI_SRC);

    irqp_state_t s_d, s_q;
    irqp_op_e    op;
    logic        busy_q;
    logic        req_go;
    logic        take;
    logic [PRIO_W-1:0] thr_new;
    logic [PRIO_W-1:0] ipi_new;
    logic [PRIO_W-1:0] arg_lo;
    logic        ipi_en;
    logic        ipi_fire;
    logic        ipi_bounce;

    assign op      = irqp_op_e'(cmd_op);
    assign busy_q  = s_q.src != '0;
    assign req_go  = req_valid && !cmd_valid && (req_src != '0);
    assign arg_lo  = cmd_data[PRIO_W-1:0];
    assign thr_new = (op == OP_EOI)     ? cmd_data[WORD_W-1:SRC_W] :
                     (op == OP_SET_THR) ? arg_lo : s_q.thr;
    assign ipi_new = (op == OP_SET_IPI) ? arg_lo : s_q.ipi_prio;
    assign ipi_en  = cmd_valid && ((op == OP_EOI) || (op == OP_SET_IPI) ||
                     ((op == OP_SET_THR) && (arg_lo >= s_q.thr)));

    irqp_admit #(.PW(PRIO_W)) i_admit (
        .in_prio   (req_prio),
        .thr       (s_q.thr),
        .busy      (busy_q),
        .pend_prio (s_q.pend_prio),
        .take      (take)
    );

    irqp_ipi #(.PW(PRIO_W)) i_ipi (
        .en         (ipi_en),
        .ipi_prio   (ipi_new),
        .thr        (thr_new),
        .busy       (busy_q),
        .owned      (s_q.owned),
        .pend_prio  (s_q.pend_prio),
        .fire       (ipi_fire),
        .bounce_old (ipi_bounce)
    );

    always_comb begin
        s_d        = s_q;
        s_d.rsp_v  = 1'b0;
        s_d.rej_v  = 1'b0;
        s_d.eoi_v  = 1'b0;
        s_d.resend = 1'b0;
        if (cmd_valid) begin
            unique case (op)
                OP_POLL: begin
                    s_d.rsp_v = 1'b1;
                    s_d.rsp_d = {s_q.thr, s_q.src};
                end
                OP_ACCEPT: begin
                    s_d.rsp_v     = 1'b1;
                    s_d.rsp_d     = {s_q.thr, s_q.src};
                    s_d.thr       = s_q.pend_prio;
                    s_d.src       = '0;
                    s_d.pend_prio = MASKED;
                    s_d.owned     = 1'b0;
                    s_d.irq       = 1'b0;
                end
                OP_EOI: begin
                    s_d.thr    = thr_new;
                    s_d.eoi_v  = 1'b1;
                    s_d.eoi_s  = cmd_data[SRC_W-1:0];
                    s_d.resend = 1'b1;
                end
                OP_SET_THR: begin
                    s_d.thr = thr_new;
                    if (arg_lo < s_q.thr) begin
                        if (busy_q && (arg_lo <= s_q.pend_prio)) begin
                            s_d.src       = '0;
                            s_d.pend_prio = MASKED;
                            s_d.owned     = 1'b0;
                            s_d.irq       = 1'b0;
                            if (s_q.owned) begin
                                s_d.rej_v = 1'b1;
                                s_d.rej_s = s_q.src;
                            end
                        end
                    end else begin
                        s_d.resend = 1'b1;
                    end
                end
                OP_SET_IPI: begin
                    s_d.ipi_prio = ipi_new;
                end
                default: begin
                end
            endcase
            if (ipi_fire) begin
                if (ipi_bounce) begin
                    s_d.rej_v = 1'b1;
                    s_d.rej_s = s_q.src;
                end
                s_d.src       = IPI_NUM;
                s_d.pend_prio = ipi_new;
                s_d.owned     = 1'b0;
                s_d.irq       = 1'b1;
            end
        end else if (req_go) begin
            s_d.rej_v = 1'b1;
            if (take) begin
                s_d.rej_v     = busy_q && s_q.owned;
                s_d.rej_s     = s_q.src;
                s_d.src       = req_src;
                s_d.pend_prio = req_prio;
                s_d.owned     = 1'b1;
                s_d.irq       = 1'b1;
            end else begin
                s_d.rej_s = req_src;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.pend_prio <= MASKED;
            s_q.ipi_prio  <= MASKED;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_ready  = 1'b1;
    assign req_ready  = !cmd_valid;
    assign rsp_valid  = s_q.rsp_v;
    assign rsp_data   = s_q.rsp_d;
    assign irq_out    = s_q.irq;
    assign rej_valid  = s_q.rej_v;
    assign rej_src    = s_q.rej_s;
    assign eoi_valid  = s_q.eoi_v;
    assign eoi_src    = s_q.eoi_s;
    assign resend_req = s_q.resend;

    // R2: the line follows the pending source register
    p_line_tracks_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (s_q.src != '0));

    // R2: an empty slot always carries the masked priority
    p_empty_is_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.src == '0) |-> (s_q.pend_prio == MASKED));

    p_untaken_bounced_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cmd_valid && (req_src != '0) && (req_prio >= s_q.thr))
        |=> (rej_valid && rej_src == $past(req_src)));

    p_accept_drops_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_ACCEPT)
        |=> (!irq_out && rsp_valid && rsp_data == $past({s_q.thr, s_q.src})));

    p_poll_keeps_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_POLL) |=> (rsp_valid && $stable(irq_out)));

    p_ipi_raises_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_SET_IPI && arg_lo < s_q.thr && s_q.src == '0)
        |=> irq_out);

    p_eoi_forwarded_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_EOI)
        |=> (eoi_valid && resend_req && eoi_src == $past(cmd_data[SRC_W-1:0])));

    p_cmd_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (!req_ready && cmd_ready));

endmodule

// File: tb/test_irq_presenter.sv
module test_irq_presenter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_src = '0;
    logic [7:0]  req_prio = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = '0;
    logic [31:0] cmd_data = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        irq_out;
    logic        rej_valid;
    logic [23:0] rej_src;
    logic        eoi_valid;
    logic [23:0] eoi_src;
    logic        resend_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_presenter i_irq_presenter (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src), .req_prio(req_prio),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq_out(irq_out),
        .rej_valid(rej_valid), .rej_src(rej_src), .eoi_valid(eoi_valid), .eoi_src(eoi_src),
        .resend_req(resend_req)
    );

    // requirement-level model
    logic [7:0]  m_thr, m_pp, m_ipi;
    logic [23:0] m_src;
    bit          m_own;
    bit          e_rsp_v, e_rej_v, e_eoi_v, e_res;
    logic [31:0] e_rsp_d;
    logic [23:0] e_rej_s, e_eoi_s;

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic m_ipi_check();
        if (m_ipi < m_thr && (m_src == 0 || m_pp > m_ipi)) begin
            if (m_src != 0 && m_own) begin e_rej_v = 1; e_rej_s = m_src; end
            m_src = 24'd2; m_pp = m_ipi; m_own = 0;
        end
    endtask

    task automatic model(input bit cv, input logic [2:0] op, input logic [31:0] d,
                         input bit rv, input logic [23:0] rs, input logic [7:0] rp);
        logic [7:0] old;
        e_rsp_v = 0; e_rej_v = 0; e_eoi_v = 0; e_res = 0;
        e_rsp_d = '0; e_rej_s = '0; e_eoi_s = '0;
        if (cv) begin
            case (op)
                3'd0: begin e_rsp_v = 1; e_rsp_d = {m_thr, m_src}; end
                3'd1: begin
                    e_rsp_v = 1; e_rsp_d = {m_thr, m_src};
                    m_thr = m_pp; m_src = 0; m_pp = 8'hFF; m_own = 0;
                end
                3'd2: begin
                    m_thr = d[31:24]; e_eoi_v = 1; e_eoi_s = d[23:0]; e_res = 1;
                    m_ipi_check();
                end
                3'd3: begin
                    old = m_thr; m_thr = d[7:0];
                    if (d[7:0] < old) begin
                        if (m_src != 0 && d[7:0] <= m_pp) begin
                            if (m_own) begin e_rej_v = 1; e_rej_s = m_src; end
                            m_src = 0; m_pp = 8'hFF; m_own = 0;
                        end
                    end else begin
                        e_res = 1; m_ipi_check();
                    end
                end
                3'd4: begin m_ipi = d[7:0]; m_ipi_check(); end
                default: ;
            endcase
        end else if (rv && rs != 0) begin
            if (rp < m_thr && (m_src == 0 || rp < m_pp)) begin
                if (m_src != 0 && m_own) begin e_rej_v = 1; e_rej_s = m_src; end
                m_src = rs; m_pp = rp; m_own = 1;
            end else begin
                e_rej_v = 1; e_rej_s = rs;
            end
        end
    endtask

    // one stimulus across one rising edge; outputs compared on the next falling edge
    task automatic step(input string tag, input bit cv, input logic [2:0] op, input logic [31:0] d,
                        input bit rv, input logic [23:0] rs, input logic [7:0] rp);
        cmd_valid = cv; cmd_op = op; cmd_data = d;
        req_valid = rv; req_src = rs; req_prio = rp;
        #1;
        if (cv) check(tag, "req_ready", {31'd0, req_ready}, 32'd0);
        check(tag, "cmd_ready", {31'd0, cmd_ready}, 32'd1);
        model(cv, op, d, rv, rs, rp);
        @(negedge clk);
        cmd_valid = 0; req_valid = 0;
        check(tag, "irq_out", {31'd0, irq_out}, {31'd0, (m_src != 0)});
        check(tag, "rej_valid", {31'd0, rej_valid}, {31'd0, e_rej_v});
        if (e_rej_v) check(tag, "rej_src", {8'd0, rej_src}, {8'd0, e_rej_s});
        check(tag, "eoi_valid", {31'd0, eoi_valid}, {31'd0, e_eoi_v});
        if (e_eoi_v) check(tag, "eoi_src", {8'd0, eoi_src}, {8'd0, e_eoi_s});
        check(tag, "resend_req", {31'd0, resend_req}, {31'd0, e_res});
        check(tag, "rsp_valid", {31'd0, rsp_valid}, {31'd0, e_rsp_v});
        if (e_rsp_v) check(tag, "rsp_data", rsp_data, e_rsp_d);
    endtask

    task automatic cmd(input string tag, input logic [2:0] op, input logic [31:0] d);
        step(tag, 1, op, d, 0, 24'd0, 8'd0);
        step({tag, "/poll R7"}, 1, 3'd0, 32'd0, 0, 24'd0, 8'd0);
    endtask

    task automatic req(input string tag, input logic [23:0] s, input logic [7:0] p);
        step(tag, 0, 3'd0, 32'd0, 1, s, p);
        step({tag, "/poll R2"}, 1, 3'd0, 32'd0, 0, 24'd0, 8'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        m_thr = 0; m_pp = 8'hFF; m_ipi = 8'hFF; m_src = 0; m_own = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state at the ports, then through a poll
        check("R1", "irq_out", {31'd0, irq_out}, 32'd0);
        check("R1", "rej_valid", {31'd0, rej_valid}, 32'd0);
        check("R1", "resend_req", {31'd0, resend_req}, 32'd0);
        step("R1 poll", 1, 3'd0, 32'd0, 0, 24'd0, 8'd0);

        // R3/R4/R5: admission sweep over threshold, prior pending state and priority
        foreach (m_thr[b]) ; // no-op to keep model names referenced
        for (int t = 0; t < 3; t++) begin
            for (int pre = 0; pre < 3; pre++) begin
                for (int p = 0; p < 256; p += 15) begin
                    cmd("R6 clear", 3'd1, 32'd0);
                    cmd("R8/R9 thr", 3'd3, (t == 0) ? 32'h00 : (t == 1) ? 32'h40 : 32'hFF);
                    if (pre == 1) req("R5 first", 24'd100, 8'h30);
                    if (pre == 2) req("R5 first", 24'd101, 8'h05);
                    req("R3 R4 R5 sweep", 24'd200 + 24'(p), 8'(p));
                end
            end
        end

        // R3: source zero has no effect
        cmd("R9 open", 3'd3, 32'hFF);
        req("R3 zero src", 24'd0, 8'h01);

        // R6: accept then threshold equals old pending priority
        req("R5 take", 24'd5, 8'h20);
        cmd("R6 accept", 3'd1, 32'd0);

        // R8: more-favoured threshold drops or keeps pending source
        cmd("R9 open", 3'd3, 32'hFF);
        req("R5 take", 24'd7, 8'h40);
        cmd("R8 keep", 3'd3, 32'h50);
        cmd("R8 drop", 3'd3, 32'h40);

        // R10/R11: IPI injection, preemption and displacement
        cmd("R9 open", 3'd3, 32'hFF);
        cmd("R10 ipi", 3'd4, 32'h10);
        req("R11 ipi displaced no reject", 24'd9, 8'h05);
        cmd("R11 ipi loses", 3'd4, 32'h08);
        cmd("R11 ipi wins", 3'd4, 32'h03);

        // R12: end-of-interrupt with IPI recheck
        cmd("R12 eoi", 3'd2, 32'hFF000009);
        cmd("R6 accept ipi", 3'd1, 32'd0);
        cmd("R12 eoi reopen", 3'd2, 32'h80000002);

        // R9: equal threshold value counts as not more favoured
        cmd("R9 equal", 3'd3, 32'h80);

        // R13: unknown ops and command priority over request
        for (int o = 5; o < 8; o++) cmd("R13 unknown op", 3'(o), 32'hFFFFFFFF);
        step("R13 arbitration", 1, 3'd0, 32'd0, 1, 24'd44, 8'h00);
        step("R13 after", 1, 3'd0, 32'd0, 0, 24'd0, 8'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule